// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block decodes bus accesses for a 4 KB window of on-chip peripheral registers whose location in the address space is set by software. A 32-bit relocation register lives at a fixed word address. The upper twenty bits of its value give the aligned start of the window, and its lowest bit enables the window. Software can therefore place the whole group of module registers wherever the system memory map needs them.

On each access the decoder checks the address against the relocation register and the window. When the address falls inside one of six sub-ranges of the window, the decoder raises the select line for that submodule: system integration, port registers, chip-select registers, timers, serial, or DMA. It also passes on the 12-bit offset relative to the window. The port range lies inside the system integration range and takes priority over it there. An access that lands inside an enabled window but in no sub-range raises a miss flag, which the fabric may turn into a bus error. The select, miss and offset outputs are combinational from the access inputs and the registered relocation value.

Top module: `pwin_decoder`

## Requirements
- R1: After reset the relocation register reads 0x00000000, the window is disabled, and no window select and no miss assert.
- R2: A write access (acc_valid=1, acc_write=1) to any byte of word address 0x0003FF00..0x0003FF03 updates the relocation register at the next clock edge, one byte per set bit of acc_be (bit n covers data bits 8n+7:8n). base_value always returns all 32 stored bits. reg_sel is high for any valid access to that word.
- R3: While bit 0 of the relocation register is 0, sel stays 0 and miss stays 0 for every address.
- R4: With bit 0 set, an address is in the window when its bits 31:12 equal relocation bits 31:12. Relocation bits 11:1 do not affect decoding. For an address in the window, offset equals address bits 11:0. Addresses outside the window raise neither sel nor miss.
- R5: Window offsets 0x000..0x00F and 0x020..0x03F raise sel[0] (system integration).
- R6: Window offsets 0x010..0x01F raise sel[1] (ports) and not sel[0], even though they also lie inside the system integration range.
- R7: Offsets 0x040..0x05F raise sel[2] (chip selects), and offsets 0x600..0x67F raise sel[3] (timers).
- R8: Offsets 0x700..0x723 raise sel[4] (serial), and offsets 0x780..0x7BF raise sel[5] (DMA).
- R9: An access in the enabled window outside every listed range raises miss and no sel bit.
- R10: At most one sel bit is high. The relocation register's own address takes priority over any window that covers it, so that access gives reg_sel=1, sel=0 and miss=0.
- R11: Decoding during the cycle of a relocation write uses the old value. The new value takes effect from the following access. The register holds its value when it is not written.
- R12: With acc_valid low, sel, miss and reg_sel are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access byte address |
| acc_be | input | 4 | Byte enables for a relocation write |
| acc_wdata | input | 32 | Write data |
| sel | output | 6 | One-hot submodule select (SYS, PORT, CS, TMR, SER, DMA) |
| miss | output | 1 | Enabled window hit that matches no sub-range |
| offset | output | 12 | Window-relative offset |
| reg_sel | output | 1 | Access targets the relocation register |
| base_value | output | 32 | Current relocation register contents |

## Verification
On every cycle the assertions check several properties. At most one select is high. A miss never coincides with a select. A disabled window or an idle bus produces no select and no miss. The relocation address shadows the window. The register changes only on a write to its own word, and the enable bit follows a write to byte 0.

Only the bench's sweeps can show that each offset maps to the right submodule, with the port range cut out of the system range at its exact edges. They also show that relocation moves the whole map and that partial-byte writes land correctly.

// File: rtl/pwin_pkg.sv
package pwin_pkg;

    localparam int WIN_BITS = 12;
    localparam int NUM_SUB  = 6;

    typedef enum logic [2:0] {
        SUB_SYS  = 3'd0,
        SUB_PORT = 3'd1,
        SUB_CS   = 3'd2,
        SUB_TMR  = 3'd3,
        SUB_SER  = 3'd4,
        SUB_DMA  = 3'd5
    } sub_e;

    typedef logic [WIN_BITS-1:0] off_t;
    typedef logic [NUM_SUB-1:0]  sel_t;

    // Inclusive lower bound of each sub-range, indexed by sub_e
    function automatic off_t sub_lo(int idx);
        case (idx)
            0:       return 12'h000;
            1:       return 12'h010;
            2:       return 12'h040;
            3:       return 12'h600;
            4:       return 12'h700;
            default: return 12'h780;
        endcase
    endfunction

    // Inclusive upper bound of each sub-range
    function automatic off_t sub_hi(int idx);
        case (idx)
            0:       return 12'h03F;
            1:       return 12'h01F;
            2:       return 12'h05F;
            3:       return 12'h67F;
            4:       return 12'h723;
            default: return 12'h7BF;
        endcase
    endfunction

    // Set of narrower ranges nested inside range idx that override it
    function automatic sel_t sub_inner(int idx);
        sel_t m;
        m = '0;
        if (idx == 0) m[SUB_PORT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pwin_base_reg.sv
module pwin_base_reg #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   base_q
);
    localparam int NUM_BYTES = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] base;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (wr_be[b]) st_d.base[b*8 +: 8] = wr_data[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q = st_q.base;

    AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base_q)); // R11

    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0]) |=> (base_q[0] == $past(wr_data[0]))); // R2

endmodule

// File: rtl/pwin_range_match.sv
module pwin_range_match
    import pwin_pkg::*;
(
    input  off_t offset,
    output sel_t raw_hit
);
    for (genvar g = 0; g < NUM_SUB; g++) begin : g_rng
        localparam off_t LO = sub_lo(g);
        localparam off_t HI = sub_hi(g);
        if (LO == '0) begin : g_from_zero
            assign raw_hit[g] = (offset <= HI);
        end else begin : g_bounded
            assign raw_hit[g] = (offset >= LO) && (offset <= HI);
        end
    end

endmodule

// File: rtl/pwin_nest_resolve.sv
module pwin_nest_resolve
    import pwin_pkg::*;
(
    input  sel_t raw_hit,
    output sel_t final_hit
);
    for (genvar g = 0; g < NUM_SUB; g++) begin : g_res
        localparam sel_t INNER = sub_inner(g);
        assign final_hit[g] = raw_hit[g] && !(|(raw_hit & INNER));
    end

endmodule

// File: rtl/pwin_decoder.sv
module pwin_decoder
    import pwin_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] REG_ADDR = 32'h0003_FF00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [3:0]          acc_be,
    input  logic [31:0]         acc_wdata,
    output logic [NUM_SUB-1:0]  sel,
    output logic                miss,
    output logic [WIN_BITS-1:0] offset,
    output logic                reg_sel,
    output logic [31:0]         base_value
);
    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [31:0] base_q;
    logic        reg_hit, win_en, win_hit, wr_en;
    sel_t        raw_hit, final_hit;

    assign reg_hit = acc_valid && (acc_addr[ADDR_W-1:2] == REG_ADDR[ADDR_W-1:2]);
    assign wr_en   = reg_hit && acc_write;

    pwin_base_reg #(.DATA_W(32)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (acc_be),
        .wr_data (acc_wdata),
        .base_q  (base_q)
    );

    assign win_en  = base_q[0];
    assign win_hit = acc_valid && win_en && !reg_hit &&
                     (acc_addr[ADDR_W-1:WIN_BITS] == base_q[ADDR_W-1:WIN_BITS]);
    assign offset  = acc_addr[WIN_BITS-1:0];

    pwin_range_match u_match (
        .offset  (offset),
        .raw_hit (raw_hit)
    );

    pwin_nest_resolve u_resolve (
        .raw_hit   (raw_hit),
        .final_hit (final_hit)
    );

    always_comb begin
        sel  = win_hit ? final_hit : '0;
        miss = win_hit && (final_hit == '0);
    end

    assign reg_sel    = reg_hit;
    assign base_value = base_q;

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R10

    AST_MISS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (sel == '0)); // R9

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !base_value[0] |-> (sel == '0 && !miss)); // R3

    AST_REG_SHADOWS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (sel == '0 && !miss)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (sel == '0 && !miss && !reg_sel)); // R12

endmodule

// File: tb/pwin_decoder_bench.sv
module pwin_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic [5:0]  sel;
    logic        miss;
    logic [11:0] offset;
    logic        reg_sel;
    logic [31:0] base_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] model_base = '0;

    always #2 clk = ~clk;

    pwin_decoder u_pwin_decoder (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
        .sel(sel), .miss(miss), .offset(offset), .reg_sel(reg_sel),
        .base_value(base_value)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected decode computed arithmetically from the requirements
    task automatic probe(input logic [31:0] a);
        logic [5:0] es;
        logic em, eb;
        int o;
        string req;
        es = '0; em = 1'b0;
        eb = (a[31:2] == 30'h0000_FFC0);
        o  = int'(a[11:0]);
        if (eb) req = "R10";
        else if (!model_base[0]) req = "R3";
        else if (a[31:12] != model_base[31:12]) req = "R4";
        else begin
            if (o >= 'h010 && o <= 'h01F)      begin es = 6'b000010; req = "R6"; end
            else if (o <= 'h03F)               begin es = 6'b000001; req = "R5"; end
            else if (o >= 'h040 && o <= 'h05F) begin es = 6'b000100; req = "R7"; end
            else if (o >= 'h600 && o <= 'h67F) begin es = 6'b001000; req = "R7"; end
            else if (o >= 'h700 && o <= 'h723) begin es = 6'b010000; req = "R8"; end
            else if (o >= 'h780 && o <= 'h7BF) begin es = 6'b100000; req = "R8"; end
            else                               begin em = 1'b1;      req = "R9"; end
        end
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        #1;
        chk(req, {sel, miss, reg_sel}, {es, em, eb});
        if (es != 0 || em) chk("R4", offset, a[11:0]);
    endtask

    task automatic wr_base(input logic [31:0] d, input logic [3:0] be, input logic [31:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_be = be; acc_wdata = d;
        #1;
        chk("R11", base_value, model_base);
        chk("R2", reg_sel, 1'b1);
        @(posedge clk);
        for (int b = 0; b < 4; b++) if (be[b]) model_base[b*8 +: 8] = d[b*8 +: 8];
        #1;
        chk("R2", base_value, model_base);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", base_value, 32'h0);
        chk("R1", {sel, miss}, 7'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", {sel, miss, reg_sel}, 8'h0);
        // R1 / R3: disabled window at reset
        probe(32'h0000_0010);
        probe(32'h0000_0700);
        // R3: tag written but enable clear
        wr_base(32'h0000_5000, 4'hF, 32'h0003_FF00);
        for (int i = 0; i < 64; i++) probe(32'h0000_5000 + i * 64);
        // R4 with junk in bits 11:1, full sweep at the top of the map
        wr_base(32'hFFFF_FAB7, 4'hF, 32'h0003_FF02);
        for (int i = 0; i < 4096; i++) probe(32'hFFFF_F000 + i);
        probe(32'hFFFF_E010);
        probe(32'h0000_0010);
        // R12: idle bus
        @(negedge clk); acc_valid = 1'b0; acc_addr = 32'hFFFF_F010; #1;
        chk("R12", {sel, miss, reg_sel}, 8'h0);
        // R10: window covering the relocation register itself
        wr_base(32'h0003_F001, 4'hF, 32'h0003_FF01);
        for (int i = 0; i < 4096; i++) probe(32'h0003_F000 + i);
        probe(32'h0003_E040);
        probe(32'h0004_0040);
        // R2: partial write clears only the enable byte
        wr_base(32'h0000_0000, 4'b0001, 32'h0003_FF03);
        chk("R2", base_value, 32'h0003_F000);
        probe(32'h0003_F010);
        // R2: upper bytes only, then re-enable
        wr_base(32'h1234_0000, 4'b1100, 32'h0003_FF00);
        wr_base(32'h0000_0001, 4'b0001, 32'h0003_FF00);
        probe(32'h1234_0724);
        probe(32'h1234_0723);
        probe(32'h1234_077F);
        probe(32'h1234_0780);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule